// File: doc/BRIEF.md
# SPI Command Register Interface

This block is the serial front end of a CAN controller's register file. A host selects it by pulling an active-low chip select and clocks in bytes on SI. The first byte after select is always an instruction. The instructions cover a soft reset, sequential reads and writes with an auto-incrementing address pointer, shortcut pointers into the receive and transmit message buffers, a request-to-send, two single-byte status polls that repeat while clocked, and a masked bit modify. SCK, SI and chip select are sampled through synchronizers on a faster system clock, and SO is shifted back on falling SCK edges. Both SPI mode 0,0 and mode 1,1 are accepted without configuration.

The register file sits outside the block. The block presents a read address and takes the read byte back combinationally. It issues single-cycle write strobes with address and data. Side-band inputs carry the receive and transmit interrupt flags, the transmit-request bits and per-buffer receive information. Side-band pulse outputs request receive-flag clears, transmit requests and a soft reset of the controller.

Top module: `spi_cmd_regif`

## Requirements
- R1: SI is captured on rising SCK and SO changes on falling SCK, for SCK idling low (mode 0,0) or high (mode 1,1); the first complete byte after chip select falls is the instruction, and raising chip select ends the operation and returns to instruction decode.
- R2: Instruction 0x03 followed by an address byte streams out the register at that address, then the following addresses, one byte per 8 clocks, with the 8-bit pointer wrapping from 0xFF to 0x00.
- R3: Instruction 0x02 followed by an address writes each complete data byte at the pointer and then increments it; a byte is committed on the eighth rising SCK edge, and a byte cut short by chip select rising is not written while earlier bytes stay written.
- R4: Instruction 1001_0nm0 starts a sequential read at 0x61 (nm=00), 0x66 (01), 0x71 (10) or 0x76 (11); when chip select then rises, rx_clr_o bit n pulses for one cycle. No other instruction pulses rx_clr_o.
- R5: Instruction 0100_0abc starts a sequential write at 0x31, 0x36, 0x41, 0x46, 0x51 or 0x56 for abc = 0 to 5; abc = 6 or 7 writes nothing.
- R6: Instruction 1000_0xyz pulses rts_o with value xyz (bit 0 for buffer 0) for one cycle; xyz = 000 produces no pulse.
- R7: Instruction 0xA0 returns, from bit 7 down to bit 0, {tx_if[2], tx_req[2], tx_if[1], tx_req[1], tx_if[0], tx_req[0], rx_if[1], rx_if[0]}, and repeats that byte for every further 8 clocks.
- R8: Instruction 0xB0 returns {rx_if[1], rx_if[0], 0, info} where info is rx0_info_i if rx_if[0] is set, else rx1_info_i if rx_if[1] is set, else 0 (info bit 4 extended ID, bit 3 remote, bits 2:0 filter hit), repeating while clocked.
- R9: Instruction 0x05, address, mask, data writes (old & ~mask) | (data & mask) at the address when it is in the bit-modifiable set (default 0x0C, 0x0D, 0x0F, 0x28 to 0x2D, 0x30, 0x40, 0x50, 0x60, 0x70), and writes data unchanged at any other address; further bytes in the same select are ignored.
- R10: Instruction 0xC0 pulses soft_rst_o for one cycle and nothing else happens until chip select rises.
- R11: so_oe_o is low while chip select is high and during instruction and address bytes; it is high only during the data phase of a read or status poll. Undefined instructions produce no write, no pulse and no output enable until chip select rises.
- R12: While rst_ni is low all strobes, pulses and so_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for SO |
| rd_addr_o | output | ADDR_W | Register file read address (current pointer) |
| rd_data_i | input | 8 | Register file read data for rd_addr_o |
| wr_en_o | output | 1 | Register write strobe, one cycle |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | 8 | Register write data |
| rx_if_i | input | 2 | Receive-buffer-full flags, bit n for buffer n |
| tx_if_i | input | 3 | Transmit-done flags, bit n for buffer n |
| tx_req_i | input | 3 | Transmit-request bits, bit n for buffer n |
| rx0_info_i | input | 5 | Buffer 0 info: extended ID, remote, filter hit |
| rx1_info_i | input | 5 | Buffer 1 info: extended ID, remote, filter hit |
| rx_clr_o | output | 2 | Receive flag clear pulse, bit n for buffer n |
| rts_o | output | 3 | Transmit request pulse, bit n for buffer n |
| soft_rst_o | output | 1 | Soft reset pulse to the controller |

## Verification
The assertions take for granted that each SCK level lasts at least four system clocks, that SI is steady around the rising SCK edge, and that chip select stays high for several system clocks once raised and changes only while SCK is at its idle level. Under those conditions a byte completion, a read-ahead load and an SO shift never fall in the same cycle. The bench holds every SCK level for eight system clocks, waits a half period after moving chip select before the first edge, and leaves a gap of sixteen clocks between transactions, in both SPI modes.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int N_TXB  = 3;
  localparam int N_RXB  = 2;
  localparam int INFO_W = 5;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_MASK, ST_BMD, ST_STAT, ST_IGN
  } st_e;

  typedef enum logic [1:0] {NX_RD, NX_WR, NX_BM} nx_e;

  function automatic logic [7:0] rxb_ptr(input logic n, input logic m);
    return 8'h61 + {3'b000, n, 4'h0} + (m ? 8'd5 : 8'd0);
  endfunction

  function automatic logic [7:0] ltx_ptr(input logic [2:0] abc);
    return 8'h31 + {2'b00, abc[2:1], 4'h0} + (abc[0] ? 8'd5 : 8'd0);
  endfunction

  function automatic logic [255:0] bm_default();
    logic [255:0] r;
    r = '0;
    r[8'h0C] = 1'b1;
    r[8'h0D] = 1'b1;
    r[8'h0F] = 1'b1;
    for (int a = 8'h28; a <= 8'h2D; a++) r[a] = 1'b1;
    for (int b = 3; b <= 7; b++) r[b*16] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {STAGES{RST_VAL[g]}};
      else         pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/spi_byte_rx.sv
`timescale 1ns/1ps
module spi_byte_rx
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (rise_i) begin
        sr_q  <= {sr_q[BYTE_W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          done_o <= 1'b1;
          byte_o <= {sr_q, bit_i};
        end
      end
    end
  end

  // R1: deselect restarts byte framing
  assert_cnt_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_done_on_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rise_i) && !$past(clr_i));

endmodule

// File: rtl/spi_byte_tx.sv
`timescale 1ns/1ps
module spi_byte_tx
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              shift_i,
  output logic              so_o
);

  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      so_o <= 1'b0;
    end else if (load_i) begin
      sr_q <= data_i;
    end else if (shift_i) begin
      so_o <= sr_q[BYTE_W-1];
      sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  // R1: a load never competes with a falling-edge shift
  assert_load_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !shift_i);

endmodule

// File: rtl/spi_cmd_regif.sv
`timescale 1ns/1ps
module spi_cmd_regif
  import spi_cmd_pkg::*;
#(
  parameter int                     ADDR_W      = 8,
  parameter int                     SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] BM_MAP      = bm_default()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic [N_RXB-1:0]  rx_if_i,
  input  logic [N_TXB-1:0]  tx_if_i,
  input  logic [N_TXB-1:0]  tx_req_i,
  input  logic [INFO_W-1:0] rx0_info_i,
  input  logic [INFO_W-1:0] rx1_info_i,
  output logic [N_RXB-1:0]  rx_clr_o,
  output logic [N_TXB-1:0]  rts_o,
  output logic              soft_rst_o
);

  logic [2:0] pins_s;
  logic       cs_s, sck_s, si_s, sck_d, cs_d;
  logic       sck_rise, sck_fall, cs_rise;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sck_s, si_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;

  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  spi_byte_rx u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cs_s),
    .rise_i(sck_rise),
    .bit_i (si_s),
    .done_o(byte_done),
    .byte_o(rx_byte)
  );

  st_e               st_q;
  nx_e               nx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] mask_q;
  logic              load_q, stat_rx_q, clr_arm_q, clr_sel_q, bm_q;

  logic [BYTE_W-1:0] rd_stat, rx_stat, tx_data, bm_mask;
  logic [INFO_W-1:0] rx_sel;

  assign rd_stat = {tx_if_i[2], tx_req_i[2], tx_if_i[1], tx_req_i[1],
                    tx_if_i[0], tx_req_i[0], rx_if_i[1], rx_if_i[0]};
  assign rx_sel  = rx_if_i[0] ? rx0_info_i : (rx_if_i[1] ? rx1_info_i : '0);
  assign rx_stat = {rx_if_i[1], rx_if_i[0], 1'b0, rx_sel};
  assign tx_data = (st_q == ST_STAT) ? (stat_rx_q ? rx_stat : rd_stat) : rd_data_i;
  assign bm_mask = BM_MAP[ptr_q] ? mask_q : '1;
  assign rd_addr_o = ptr_q;

  spi_byte_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_q),
    .data_i (tx_data),
    .shift_i(sck_fall & ~cs_s),
    .so_o   (so_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CMD;
      nx_q       <= NX_RD;
      ptr_q      <= '0;
      mask_q     <= '0;
      load_q     <= 1'b0;
      stat_rx_q  <= 1'b0;
      clr_arm_q  <= 1'b0;
      clr_sel_q  <= 1'b0;
      bm_q       <= 1'b0;
      so_oe_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rx_clr_o   <= '0;
      rts_o      <= '0;
      soft_rst_o <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      rx_clr_o   <= '0;
      rts_o      <= '0;
      soft_rst_o <= 1'b0;
      load_q     <= 1'b0;
      if (cs_s) begin
        st_q    <= ST_CMD;
        so_oe_o <= 1'b0;
        if (cs_rise && clr_arm_q) rx_clr_o[clr_sel_q] <= 1'b1;
        if (cs_rise) clr_arm_q <= 1'b0;
      end else if (load_q) begin
        so_oe_o <= 1'b1;
        if (st_q == ST_RD) ptr_q <= ptr_q + 1'b1;
      end else if (byte_done) begin
        unique case (st_q)
          ST_CMD: begin
            casez (rx_byte)
              8'hC0: begin soft_rst_o <= 1'b1; st_q <= ST_IGN; end
              8'h03: begin nx_q <= NX_RD; st_q <= ST_ADDR; end
              8'h02: begin nx_q <= NX_WR; st_q <= ST_ADDR; end
              8'h05: begin nx_q <= NX_BM; st_q <= ST_ADDR; end
              8'hA0: begin stat_rx_q <= 1'b0; st_q <= ST_STAT; load_q <= 1'b1; end
              8'hB0: begin stat_rx_q <= 1'b1; st_q <= ST_STAT; load_q <= 1'b1; end
              8'b1001_0??0: begin
                ptr_q     <= ADDR_W'(rxb_ptr(rx_byte[2], rx_byte[1]));
                clr_arm_q <= 1'b1;
                clr_sel_q <= rx_byte[2];
                st_q      <= ST_RD;
                load_q    <= 1'b1;
              end
              8'b0100_0???: begin
                if (rx_byte[2:0] < 3'd6) begin
                  ptr_q <= ADDR_W'(ltx_ptr(rx_byte[2:0]));
                  st_q  <= ST_WR;
                end else begin
                  st_q <= ST_IGN;
                end
              end
              8'b1000_0???: begin
                rts_o <= rx_byte[2:0];
                st_q  <= ST_IGN;
              end
              default: st_q <= ST_IGN;
            endcase
          end
          ST_ADDR: begin
            ptr_q <= rx_byte[ADDR_W-1:0];
            unique case (nx_q)
              NX_RD:   begin st_q <= ST_RD; load_q <= 1'b1; end
              NX_WR:   st_q <= ST_WR;
              default: st_q <= ST_MASK;
            endcase
          end
          ST_RD, ST_STAT: load_q <= 1'b1;
          ST_WR: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= rx_byte;
            bm_q      <= 1'b0;
            ptr_q     <= ptr_q + 1'b1;
          end
          ST_MASK: begin
            mask_q <= rx_byte;
            st_q   <= ST_BMD;
          end
          ST_BMD: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= (rd_data_i & ~bm_mask) | (rx_byte & bm_mask);
            bm_q      <= 1'b1;
            st_q      <= ST_IGN;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: output enable only in a read data phase, dropped on deselect
  assert_oe_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (st_q == ST_RD || st_q == ST_STAT));
  assert_oe_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> !so_oe_o);
  // R3: sequential write advances the pointer past the committed byte
  assert_wr_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !bm_q) |-> (ptr_q == ADDR_W'(wr_addr_o + 1'b1)));
  // R4: one buffer flag cleared, only after deselect
  assert_clr_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_clr_o) && ((|rx_clr_o) -> cs_s));
  // R6: request pulses come from instruction decode and end the command
  assert_rts_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rts_o) |-> (st_q == ST_IGN) && $past(st_q == ST_CMD));
  // R9: a single bit modify per select
  assert_bm_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && bm_q) |-> (st_q == ST_IGN));
  // R12: no strobes while in reset
  assert_reset_quiet_R12: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_en_o && !so_oe_o && (rts_o == '0) && (rx_clr_o == '0) && !soft_rst_o);

endmodule

// File: tb/spi_cmd_regif_tb.sv
`timescale 1ns/1ps
module spi_cmd_regif_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_ni, sck, cs_n, si, mode1;
  logic       so, so_oe, wr_en, soft_rst;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [1:0] rx_if, rx_clr;
  logic [2:0] tx_if, tx_req, rts;
  logic [4:0] i0, i1;

  logic [7:0] mem   [256];
  logic [7:0] exp_m [256];

  int rts_acc, clr_acc, srst_cnt, wr_cnt, oe_seen;
  int n_chk = 0, n_fail = 0;

  spi_cmd_regif u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rx_if_i(rx_if), .tx_if_i(tx_if), .tx_req_i(tx_req),
    .rx0_info_i(i0), .rx1_info_i(i1),
    .rx_clr_o(rx_clr), .rts_o(rts), .soft_rst_o(soft_rst)
  );

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rts_acc  <= rts_acc | int'(rts);
    clr_acc  <= clr_acc | int'(rx_clr);
    srst_cnt <= srst_cnt + int'(soft_rst);
    wr_cnt   <= wr_cnt + int'(wr_en);
    if (so_oe) oe_seen <= 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    mode1 = m; sck = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic start();
    rts_acc = 0; clr_acc = 0; srst_cnt = 0; wr_cnt = 0; oe_seen = 0;
    cs_n = 1'b0;
    half();
  endtask

  task automatic stop();
    if (!mode1) sck = 1'b0;
    half();
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic xb(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sck = 1'b0; si = tx[i];
      half();
      rx[i] = so;
      sck = 1'b1;
      half();
    end
  endtask

  function automatic logic [7:0] rd_stat_f(logic [1:0] r, logic [2:0] q, logic [2:0] t);
    return {t[2], q[2], t[1], q[1], t[0], q[0], r[1], r[0]};
  endfunction

  logic [7:0] rv, ev;
  logic [7:0] a;

  initial begin
    rst_ni = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; mode1 = 1'b0;
    rx_if = '0; tx_if = '0; tx_req = '0; i0 = '0; i1 = '0;
    for (int k = 0; k < 256; k++) begin
      mem[k] = 8'(k) ^ 8'h5A;
      exp_m[k] = 8'(k) ^ 8'h5A;
    end
    rts_acc = 0; clr_acc = 0; srst_cnt = 0; wr_cnt = 0; oe_seen = 0;
    repeat (5) @(negedge clk);
    chk(!so_oe && !wr_en && rts == 0 && rx_clr == 0 && !soft_rst, "R12 reset quiet", 0, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!so_oe && !wr_en, "R12 after reset", int'(so_oe), 0);

    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      // R3 sequential write
      a = 8'h20 + 8'(md * 8);
      start(); xb(8'h02, 8, rv); xb(a, 8, rv);
      chk(oe_seen == 0, "R11 oe during cmd/addr", oe_seen, 0);
      for (int i = 0; i < 4; i++) begin
        ev = 8'(md * 16 + i * 37 + 5);
        exp_m[8'(a + i)] = ev;
        xb(ev, 8, rv);
      end
      stop();
      for (int i = 0; i < 5; i++)
        chk(mem[8'(a + i)] == exp_m[8'(a + i)], "R1 R3 seq write", mem[8'(a+i)], exp_m[8'(a+i)]);
      // R3 partial byte
      a = 8'h30 + 8'(md * 2) + 8'h40;
      start(); xb(8'h02, 8, rv); xb(a, 8, rv);
      exp_m[a] = 8'hC3 ^ 8'(md); xb(exp_m[a], 8, rv); xb(8'hFF, 4, rv);
      stop();
      chk(mem[a] == exp_m[a], "R3 full byte kept", mem[a], exp_m[a]);
      chk(mem[8'(a+1)] == exp_m[8'(a+1)], "R3 partial dropped", mem[8'(a+1)], exp_m[8'(a+1)]);
      // R2 sequential read
      a = 8'h20 + 8'(md * 8);
      start(); xb(8'h03, 8, rv); xb(a, 8, rv);
      for (int i = 0; i < 4; i++) begin
        xb(8'h00, 8, rv);
        chk(rv == exp_m[8'(a + i)], "R1 R2 seq read", rv, exp_m[8'(a+i)]);
      end
      chk(so_oe == 1'b1, "R11 oe in read", int'(so_oe), 1);
      stop();
      chk(so_oe == 1'b0, "R11 oe off after cs", int'(so_oe), 0);
      chk(clr_acc == 0, "R4 plain read no clear", clr_acc, 0);
      // R2 wrap
      start(); xb(8'h02, 8, rv); xb(8'hFF, 8, rv);
      exp_m[8'hFF] = 8'h11 + 8'(md); exp_m[8'h00] = 8'h22 + 8'(md);
      xb(exp_m[8'hFF], 8, rv); xb(exp_m[8'h00], 8, rv); stop();
      start(); xb(8'h03, 8, rv); xb(8'hFF, 8, rv);
      xb(8'h00, 8, rv); chk(rv == exp_m[8'hFF], "R2 read at FF", rv, exp_m[8'hFF]);
      xb(8'h00, 8, rv); chk(rv == exp_m[8'h00], "R2 wrap to 00", rv, exp_m[8'h00]);
      stop();
      // R9 bit modify, modifiable and plain
      for (int j = 0; j < 2; j++) begin
        a = (j == 0) ? 8'h2C : 8'h33;
        ev = (j == 0) ? ((exp_m[a] & 8'hC3) | (8'h96 & 8'h3C)) : 8'h96;
        exp_m[a] = ev;
        start(); xb(8'h05, 8, rv); xb(a, 8, rv); xb(8'h3C, 8, rv); xb(8'h96, 8, rv);
        xb(8'hEE, 8, rv); stop();
        chk(mem[a] == ev, "R9 bit modify", mem[a], ev);
        chk(mem[8'(a+1)] == exp_m[8'(a+1)], "R9 extra byte ignored", mem[8'(a+1)], exp_m[8'(a+1)]);
        chk(wr_cnt == 1, "R9 single write", wr_cnt, 1);
      end
      // R10 soft reset
      start(); xb(8'hC0, 8, rv); xb(8'h02, 8, rv); xb(8'h10, 8, rv); stop();
      chk(srst_cnt == 1 && wr_cnt == 0, "R10 soft reset pulse", srst_cnt, 1);
      // R11 undefined opcodes
      for (int u = 0; u < 4; u++) begin
        logic [7:0] op;
        op = (u == 0) ? 8'h01 : (u == 1) ? 8'hFF : (u == 2) ? 8'h98 : 8'h47;
        start(); xb(op, 8, rv); xb(8'h03, 8, rv); xb(8'h00, 8, rv); xb(8'h55, 8, rv); stop();
        chk(wr_cnt == 0 && rts_acc == 0 && srst_cnt == 0 && clr_acc == 0 && oe_seen == 0,
            "R11 undefined ignored", {wr_cnt[7:0], rts_acc[7:0], oe_seen[7:0]}, 0);
      end
    end

    // R4 read RX buffer sweep
    for (int k = 0; k < 4; k++) begin
      set_mode(k[0]);
      a = 8'h61 + 8'(k[1] * 16) + 8'(k[0] * 5);
      start(); xb({5'b10010, k[1], k[0], 1'b0}, 8, rv);
      xb(8'h00, 8, rv); chk(rv == exp_m[a], "R4 rx buffer ptr", rv, exp_m[a]);
      xb(8'h00, 8, rv); chk(rv == exp_m[8'(a+1)], "R4 rx buffer seq", rv, exp_m[8'(a+1)]);
      chk(clr_acc == 0, "R4 no clear before cs", clr_acc, 0);
      stop();
      chk(clr_acc == (1 << k[1]), "R4 flag clear", clr_acc, 1 << k[1]);
    end

    // R5 load TX buffer sweep
    for (int k = 0; k < 8; k++) begin
      set_mode(k[0]);
      ev = 8'(k * 3) + 8'h90;
      start(); xb({5'b01000, 3'(k)}, 8, rv); xb(ev, 8, rv); stop();
      if (k < 6) begin
        a = 8'h31 + 8'((k / 2) * 16) + 8'((k % 2) * 5);
        exp_m[a] = ev;
        chk(mem[a] == ev && wr_cnt == 1, "R5 load tx ptr", mem[a], ev);
      end else begin
        chk(wr_cnt == 0, "R5 undefined abc", wr_cnt, 0);
      end
    end

    // R6 request to send sweep
    for (int k = 0; k < 8; k++) begin
      set_mode(k[1]);
      start(); xb({5'b10000, 3'(k)}, 8, rv); stop();
      chk(rts_acc == k, "R6 rts pulse", rts_acc, k);
    end

    // R7 read status sweep
    for (int k = 0; k < 32; k++) begin
      set_mode(k[0]);
      rx_if = 2'(k); tx_req = 3'(k >> 2); tx_if = 3'(k) ^ 3'(k >> 2);
      ev = rd_stat_f(rx_if, tx_req, tx_if);
      start(); xb(8'hA0, 8, rv);
      xb(8'h00, 8, rv); chk(rv == ev, "R7 read status", rv, ev);
      xb(8'h00, 8, rv); chk(rv == ev, "R7 status repeat", rv, ev);
      stop();
    end

    // R8 RX status sweep
    for (int k = 0; k < 16; k++) begin
      set_mode(k[1]);
      rx_if = 2'(k); i0 = 5'(k * 7 + 3); i1 = 5'(k * 5 + 17);
      ev = {rx_if[1], rx_if[0], 1'b0, rx_if[0] ? i0 : (rx_if[1] ? i1 : 5'd0)};
      start(); xb(8'hB0, 8, rv);
      xb(8'h00, 8, rv); chk(rv == ev, "R8 rx status", rv, ev);
      xb(8'h00, 8, rv); chk(rv == ev, "R8 rx status repeat", rv, ev);
      stop();
    end

    for (int k = 0; k < 256; k++)
      if (mem[k] != exp_m[k]) chk(1'b0, "R3 stray write", mem[k], exp_m[k]);
    chk(1'b1, "R3 memory image", 0, 0);
    summary();
  end

endmodule